// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

This block buffers 36-bit words between a producer on one clock and a consumer on another clock. The two clocks may be unrelated or the same. Storage depth is a power of two set by a parameter. Write and read pointers cross between the domains in Gray code through synchronizer chains. As a result, every flag is conservative: it may lag the true fill level, but it never claims space or data that is not there.

Two output disciplines are available, chosen while master reset is held. In standard mode, a word stays in storage until a read pulls it onto the output register. The two status pins then mean "empty" and "full". In fall-through mode, the oldest word is moved to the output by itself. The same two pins then mean "output holds valid data" and "a write will be accepted". Almost-empty and almost-full thresholds come from one of three built-in offsets, or are loaded after reset. Loading is either two parallel writes on the data bus or a serial bit stream.

A partial reset flushes the contents and keeps the configuration. A master reset flushes the contents and re-reads every configuration input.

Top module: `dcfifo_fwft`

## Requirements
- R1: After master reset, in standard mode `emptyOrRdy`=1 and `fullOrRdy`=0. In fall-through mode (`fwftSel`=1 during master reset) `emptyOrRdy`=0 and `fullOrRdy`=1. In both modes `rdData` is 0.
- R2: In standard mode, a written word does not reach `rdData` until a read is accepted. Words leave in the order they were written. `emptyOrRdy` is 1 exactly when no word is stored (after synchronization).
- R3: In fall-through mode, the oldest stored word appears on `rdData` with `emptyOrRdy`=1 without any read. It stays there while `rdEn` is low. An accepted read replaces it with the next word, or drops `emptyOrRdy` when none is left.
- R4: Storage holds 2^ADDR_W words. In standard mode `fullOrRdy`=1 when it is full, and in fall-through mode `fullOrRdy`=0 when it is full. A write attempted while full is discarded, and the stored words are unchanged.
- R5: A read while nothing is available (standard mode: empty; fall-through: `emptyOrRdy`=0) is discarded. `rdData` keeps its value.
- R6: `dfltSel`, sampled during master reset, picks the built-in offsets for both thresholds: 00 gives 8, 01 gives 16, 1x gives 64. `almostEmpty`=1 when the read-side level is no more than the empty offset. `almostFull`=1 when the write-side level is at least 2^ADDR_W minus the full offset. In fall-through mode the word held on the output counts toward the read-side level.
- R7: With `progSel`=01 at master reset, a write-clock cycle with `loadEn`=1 loads `wrData[ADDR_W-1:0]` as an offset. The first such load sets the empty offset, the second sets the full offset, and further loads alternate. A cycle with `loadEn`=1 never stores a word.
- R8: With `progSel`=10 at master reset, each write-clock cycle with `serEn`=1 shifts in `serData`. The first ADDR_W bits form the empty offset and the next ADDR_W bits form the full offset, each sent MSB first. Until the last bit arrives, the built-in offsets stay in force, and bits after that are ignored. `progSel` 00 or 11 means built-in offsets only.
- R9: Partial reset empties the FIFO and returns `rdData` to 0. The mode and any loaded offsets are kept.
- R10: Master reset discards loaded offsets and re-applies the built-in offset chosen by `dfltSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| masterRst | input | 1 | Full reset, active high; configuration inputs are sampled while it is high |
| partialRst | input | 1 | Flush, active high; configuration and offsets kept |
| fwftSel | input | 1 | 1 selects fall-through mode (sampled during master reset) |
| dfltSel | input | 2 | Built-in offset choice: 00=8, 01=16, 1x=64 |
| progSel | input | 2 | Offset source: 01 parallel, 10 serial, 00/11 built-in only |
| wrEn | input | 1 | Write request |
| loadEn | input | 1 | Parallel offset load strobe (write clock) |
| wrData | input | 36 | Write word; low ADDR_W bits carry a parallel offset |
| serEn | input | 1 | Serial offset bit strobe (write clock) |
| serData | input | 1 | Serial offset bit |
| fullOrRdy | output | 1 | Full (standard) or input ready (fall-through) |
| almostFull | output | 1 | Write-side level at or above the full threshold |
| rdEn | input | 1 | Read request |
| rdData | output | 36 | Output word register |
| emptyOrRdy | output | 1 | Empty (standard) or output ready (fall-through) |
| almostEmpty | output | 1 | Read-side level at or below the empty threshold |

## Verification
The bench fills storage to exactly its capacity, then pushes one more word. It then drains everything, so a design that wrapped its pointer or stored the extra word shows the wrong sequence or an early empty. It reads past empty, which exposes designs that advance the read pointer or disturb the output register. In fall-through mode it checks that the head word appears with no read and stays through idle cycles; a design that re-fetches or skips words fails this. The threshold cases sit exactly one word on each side of each offset. They are placed so that a built-in value, a swapped empty/full load, or a partial reset that clears programming gives the opposite flag value.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int WORD_W = 36;

  typedef enum logic [1:0] {
    SRC_BUILTIN  = 2'b00,
    SRC_PARALLEL = 2'b01,
    SRC_SERIAL   = 2'b10,
    SRC_BUILTIN2 = 2'b11
  } offSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic memWrite;   // write-clock domain
    logic outLoad;    // read-clock domain
  } strobe_t;
endpackage

// File: rtl/dcfifo_gsync.sv
module dcfifo_gsync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or posedge rst)
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or posedge rst)
        if (rst) stage[s] <= '0;
        else     stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dcfifo_ctrl.sv
module dcfifo_ctrl
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              masterRst,
  input  logic              ptrRst,
  input  logic              fwftSel,
  input  logic [1:0]        dfltSel,
  input  logic [1:0]        progSel,
  input  logic              wrEn,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadVal,
  input  logic              serEn,
  input  logic              serData,
  input  logic              rdEn,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              fullOrRdy,
  output logic              almostFull,
  output logic              emptyOrRdy,
  output logic              almostEmpty,
  output logic              fwftActive,
  output logic [ADDR_W:0]   wrLevel
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int OFF_W = ADDR_W;
  localparam int SER_N = 2 * OFF_W;
  localparam int CNT_W = $clog2(SER_N + 1);
  localparam logic [PTR_W-1:0] DEPTH_L = PTR_W'(2 ** ADDR_W);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [OFF_W-1:0] builtinOff(input logic [1:0] sel);
    case (sel)
      2'b00:   return OFF_W'(8);
      2'b01:   return OFF_W'(16);
      default: return OFF_W'(64);
    endcase
  endfunction

  // ---------------- configuration (write domain) ----------------
  offSrc_e          srcQ;
  logic             fwftQ;
  logic [OFF_W-1:0] aeOff, afOff;
  logic             parIdx;
  logic [SER_N-1:0] serShift, serNext;
  logic [CNT_W-1:0] serCnt;
  logic             serDone;

  assign serNext = {serShift[SER_N-2:0], serData};

  always_ff @(posedge wrClk) begin
    if (masterRst) begin
      srcQ     <= offSrc_e'(progSel);
      fwftQ    <= fwftSel;
      aeOff    <= builtinOff(dfltSel);
      afOff    <= builtinOff(dfltSel);
      parIdx   <= 1'b0;
      serShift <= '0;
      serCnt   <= '0;
      serDone  <= 1'b0;
    end else begin
      if (srcQ == SRC_PARALLEL && loadEn) begin
        if (!parIdx) aeOff <= loadVal;
        else         afOff <= loadVal;
        parIdx <= ~parIdx;
      end
      if (srcQ == SRC_SERIAL && serEn && !serDone) begin
        serShift <= serNext;
        serCnt   <= serCnt + 1'b1;
        if (serCnt == CNT_W'(SER_N - 1)) begin
          aeOff   <= serNext[SER_N-1:OFF_W];
          afOff   <= serNext[OFF_W-1:0];
          serDone <= 1'b1;
        end
      end
    end
  end

  assign fwftActive = fwftQ;

  // ---------------- write side ----------------
  logic [PTR_W-1:0] wrPtr, wrGray, rdGraySync, rdPtrInW;
  logic             isFull, doWrite;

  dcfifo_gsync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rd2wr (
    .clk(wrClk), .rst(ptrRst), .d(toGray(rdPtr)), .q(rdGraySync)
  );

  assign rdPtrInW = fromGray(rdGraySync);
  assign wrLevel  = wrPtr - rdPtrInW;
  assign isFull   = (wrLevel == DEPTH_L);
  assign doWrite  = wrEn && !loadEn && !isFull;

  always_ff @(posedge wrClk or posedge ptrRst)
    if (ptrRst) begin
      wrPtr  <= '0;
      wrGray <= '0;
    end else if (doWrite) begin
      wrPtr  <= wrPtr + 1'b1;
      wrGray <= toGray(wrPtr + 1'b1);
    end

  assign fullOrRdy  = fwftQ ? !isFull : isFull;
  assign almostFull = (wrLevel >= (DEPTH_L - PTR_W'(afOff)));

  // ---------------- read side ----------------
  logic [PTR_W-1:0] rdPtr, wrGraySync, wrPtrInR, memLevel, rdLevel;
  logic             memEmpty, outValid, outLoad;

  dcfifo_gsync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wr2rd (
    .clk(rdClk), .rst(ptrRst), .d(wrGray), .q(wrGraySync)
  );

  assign wrPtrInR = fromGray(wrGraySync);
  assign memLevel = wrPtrInR - rdPtr;
  assign memEmpty = (memLevel == '0);
  assign outLoad  = fwftQ ? (!memEmpty && (!outValid || rdEn))
                          : (rdEn && !memEmpty);

  always_ff @(posedge rdClk or posedge ptrRst)
    if (ptrRst) begin
      rdPtr    <= '0;
      outValid <= 1'b0;
    end else begin
      if (outLoad) rdPtr <= rdPtr + 1'b1;
      if (fwftQ) begin
        if (outLoad)   outValid <= 1'b1;
        else if (rdEn) outValid <= 1'b0;
      end else begin
        outValid <= 1'b0;
      end
    end

  assign rdLevel     = memLevel + PTR_W'(fwftQ && outValid);
  assign emptyOrRdy  = fwftQ ? outValid : memEmpty;
  assign almostEmpty = (rdLevel <= PTR_W'(aeOff));

  // ---------------- datapath strobes ----------------
  assign stb.memWrite = doWrite;
  assign stb.outLoad  = outLoad;
  assign wrAddr       = wrPtr[ADDR_W-1:0];
  assign rdAddr       = rdPtr[ADDR_W-1:0];
endmodule

// File: rtl/dcfifo_dpath.sv
module dcfifo_dpath
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              ptrRst,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk)
    if (stb.memWrite) store[wrAddr] <= wrData;

  always_ff @(posedge rdClk or posedge ptrRst)
    if (ptrRst)           rdData <= '0;
    else if (stb.outLoad) rdData <= store[rdAddr];
endmodule

// File: rtl/dcfifo_fwft.sv
module dcfifo_fwft
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              masterRst,
  input  logic              partialRst,
  input  logic              fwftSel,
  input  logic [1:0]        dfltSel,
  input  logic [1:0]        progSel,
  input  logic              wrEn,
  input  logic              loadEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              serEn,
  input  logic              serData,
  output logic              fullOrRdy,
  output logic              almostFull,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              emptyOrRdy,
  output logic              almostEmpty
);
  strobe_t             stb;
  logic [ADDR_W-1:0]   wrAddr, rdAddr;
  logic                ptrRst, fwftActive;
  logic [ADDR_W:0]     wrLevel;

  assign ptrRst = masterRst | partialRst;

  dcfifo_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .ptrRst(ptrRst),
    .fwftSel(fwftSel), .dfltSel(dfltSel), .progSel(progSel),
    .wrEn(wrEn), .loadEn(loadEn), .loadVal(wrData[ADDR_W-1:0]),
    .serEn(serEn), .serData(serData), .rdEn(rdEn),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullOrRdy(fullOrRdy), .almostFull(almostFull),
    .emptyOrRdy(emptyOrRdy), .almostEmpty(almostEmpty),
    .fwftActive(fwftActive), .wrLevel(wrLevel)
  );

  dcfifo_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .wrClk(wrClk), .rdClk(rdClk), .ptrRst(ptrRst), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
  parameter int ADDR_W = 7
) (
  input logic            wrClk,
  input logic            rdClk,
  input logic            masterRst,
  input logic            partialRst,
  input logic            wrEn,
  input logic            loadEn,
  input logic            rdEn,
  input logic            fwftActive,
  input logic [ADDR_W:0] wrLevel,
  input logic            almostFull,
  input logic            emptyOrRdy,
  input logic [35:0]     rdData
);
  localparam logic [ADDR_W:0] CAP = (ADDR_W + 1)'(2 ** ADDR_W);

  // R4: the write-side level never passes capacity
  p_level_bound_r4: assert property (@(posedge wrClk)
    disable iff (masterRst || partialRst) wrLevel <= CAP);

  // R4: a write against a full store does not raise the level
  p_no_overflow_r4: assert property (@(posedge wrClk)
    disable iff (masterRst || partialRst)
    (wrLevel == CAP && wrEn && !loadEn) |=> wrLevel <= $past(wrLevel));

  // R5: standard-mode read while empty leaves the output register alone
  p_empty_read_r5: assert property (@(posedge rdClk)
    disable iff (masterRst || partialRst)
    (!fwftActive && emptyOrRdy && rdEn) |=> $stable(rdData));

  // R3: fall-through head word is held until a read takes it
  p_head_hold_r3: assert property (@(posedge rdClk)
    disable iff (masterRst || partialRst)
    (fwftActive && emptyOrRdy && !rdEn) |=> (emptyOrRdy && $stable(rdData)));

  // R6: a full store is always reported almost full
  p_full_implies_af_r6: assert property (@(posedge wrClk)
    disable iff (masterRst || partialRst)
    (wrLevel == CAP) |-> almostFull);
endmodule

bind dcfifo_fwft dcfifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
  .wrEn(wrEn), .loadEn(loadEn), .rdEn(rdEn), .fwftActive(fwftActive),
  .wrLevel(wrLevel), .almostFull(almostFull), .emptyOrRdy(emptyOrRdy),
  .rdData(rdData)
);

// File: tb/dcfifo_fwft_test.sv
module dcfifo_fwft_test;
  localparam int ADDR_W = 7;
  localparam int DEPTH  = 2 ** ADDR_W;

  logic wrClk = 1'b0, rdClk = 1'b0;
  logic masterRst = 1'b1, partialRst = 1'b0;
  logic fwftSel = 1'b0;
  logic [1:0] dfltSel = 2'b00, progSel = 2'b00;
  logic wrEn = 1'b0, loadEn = 1'b0, serEn = 1'b0, serData = 1'b0, rdEn = 1'b0;
  logic [35:0] wrData = '0;
  logic fullOrRdy, almostFull, emptyOrRdy, almostEmpty;
  logic [35:0] rdData;

  int total = 0, fails = 0;

  always #4 wrClk = ~wrClk;   // 125 MHz
  always #7 rdClk = ~rdClk;   // unrelated read clock

  dcfifo_fwft #(.ADDR_W(ADDR_W)) uut (
    .wrClk(wrClk), .rdClk(rdClk), .masterRst(masterRst), .partialRst(partialRst),
    .fwftSel(fwftSel), .dfltSel(dfltSel), .progSel(progSel),
    .wrEn(wrEn), .loadEn(loadEn), .wrData(wrData), .serEn(serEn), .serData(serData),
    .fullOrRdy(fullOrRdy), .almostFull(almostFull),
    .rdEn(rdEn), .rdData(rdData), .emptyOrRdy(emptyOrRdy), .almostEmpty(almostEmpty)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge rdClk);
    repeat (6) @(posedge wrClk);
    @(negedge wrClk);
  endtask

  task automatic doMaster(input logic fw, input logic [1:0] dsel, input logic [1:0] psel);
    @(negedge wrClk);
    fwftSel = fw; dfltSel = dsel; progSel = psel; masterRst = 1'b1;
    repeat (4) @(negedge wrClk);
    masterRst = 1'b0;
    settle();
  endtask

  task automatic doPartial();
    @(negedge wrClk);
    partialRst = 1'b1;
    repeat (3) @(negedge wrClk);
    partialRst = 1'b0;
    settle();
  endtask

  task automatic writeRun(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrEn = 1'b1; wrData = 36'(base + i);
    end
    @(negedge wrClk);
    wrEn = 1'b0;
    settle();
  endtask

  task automatic loadPar(input int val);
    @(negedge wrClk);
    loadEn = 1'b1; wrData = 36'(val);
    @(negedge wrClk);
    loadEn = 1'b0;
  endtask

  task automatic shiftBits(input logic [6:0] v);
    for (int i = 6; i >= 0; i--) begin
      @(negedge wrClk);
      serEn = 1'b1; serData = v[i];
    end
    @(negedge wrClk);
    serEn = 1'b0;
  endtask

  task automatic readOne();
    @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
    settle();
  endtask

  task automatic testResetStd();
    doMaster(1'b0, 2'b00, 2'b00);
    check("R1 std empty", 36'(emptyOrRdy), 36'd1);
    check("R1 std full", 36'(fullOrRdy), 36'd0);
    check("R1 std data", rdData, 36'd0);
  endtask

  task automatic testStdOrder();
    doMaster(1'b0, 2'b00, 2'b00);
    writeRun('h50, 3);
    check("R2 not shown before read", rdData, 36'd0);
    check("R2 not empty", 36'(emptyOrRdy), 36'd0);
    readOne(); check("R2 first", rdData, 36'h50);
    readOne(); check("R2 second", rdData, 36'h51);
    readOne(); check("R2 third", rdData, 36'h52);
    check("R2 empty again", 36'(emptyOrRdy), 36'd1);
    readOne(); check("R5 read on empty keeps data", rdData, 36'h52);
  endtask

  task automatic testFullAndAf();
    int bad = 0;
    doMaster(1'b0, 2'b00, 2'b00);
    writeRun('h1000, DEPTH - 9);
    check("R6 af below default 8", 36'(almostFull), 36'd0);
    writeRun('h1000 + DEPTH - 9, 1);
    check("R6 af at default 8", 36'(almostFull), 36'd1);
    writeRun('h1000 + DEPTH - 8, 8);
    check("R4 full flag", 36'(fullOrRdy), 36'd1);
    writeRun('hDEAD, 1);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge rdClk); rdEn = 1'b1;
      @(negedge rdClk); rdEn = 1'b0;
      @(negedge rdClk);
      if (rdData !== 36'('h1000 + i)) bad++;
    end
    settle();
    check("R4 drained sequence intact", 36'(bad), 36'd0);
    check("R4 extra word dropped", 36'(emptyOrRdy), 36'd1);
    check("R4 full cleared", 36'(fullOrRdy), 36'd0);
  endtask

  task automatic testFwft();
    doMaster(1'b1, 2'b00, 2'b00);
    check("R1 fwft not ready", 36'(emptyOrRdy), 36'd0);
    check("R1 fwft input ready", 36'(fullOrRdy), 36'd1);
    writeRun('hA1, 1);
    check("R3 falls through", rdData, 36'hA1);
    check("R3 output ready", 36'(emptyOrRdy), 36'd1);
    writeRun('hA2, 1);
    check("R3 head held", rdData, 36'hA1);
    readOne(); check("R3 next after read", rdData, 36'hA2);
    readOne(); check("R3 ready drops", 36'(emptyOrRdy), 36'd0);
    readOne(); check("R5 fwft read ignored", rdData, 36'hA2);
  endtask

  task automatic testParallelAndPartial();
    doMaster(1'b0, 2'b00, 2'b01);
    loadPar(5);
    loadPar(10);
    writeRun('h200, 5);
    check("R7 ae at 5", 36'(almostEmpty), 36'd1);
    writeRun('h205, 1);
    check("R7 ae above 5", 36'(almostEmpty), 36'd0);
    readOne(); check("R7 loads not stored", rdData, 36'h200);
    doPartial();
    check("R9 flushed", 36'(emptyOrRdy), 36'd1);
    check("R9 data cleared", rdData, 36'd0);
    writeRun('h300, 6);
    check("R9 offset kept", 36'(almostEmpty), 36'd0);
    writeRun('h306, DEPTH - 6 - 11);
    check("R7 af below 10", 36'(almostFull), 36'd0);
    writeRun('h400, 1);
    check("R7 af at 10", 36'(almostFull), 36'd1);
  endtask

  task automatic testMasterDefaults();
    doMaster(1'b0, 2'b01, 2'b00);
    writeRun('h10, 16);
    check("R10 default 16 at 16", 36'(almostEmpty), 36'd1);
    writeRun('h20, 1);
    check("R10 default 16 above", 36'(almostEmpty), 36'd0);
    doMaster(1'b1, 2'b10, 2'b00);
    writeRun('h10, 64);
    check("R6 default 64 at 64", 36'(almostEmpty), 36'd1);
    writeRun('h50, 1);
    check("R6 default 64 above", 36'(almostEmpty), 36'd0);
  endtask

  task automatic testSerial();
    doMaster(1'b0, 2'b00, 2'b10);
    shiftBits(7'd3);
    writeRun('h70, 4);
    check("R8 default until done", 36'(almostEmpty), 36'd1);
    shiftBits(7'd4);
    shiftBits(7'd100);
    settle();
    check("R8 ae offset 3", 36'(almostEmpty), 36'd0);
    writeRun('h74, DEPTH - 4 - 5);
    check("R8 af below 4", 36'(almostFull), 36'd0);
    writeRun('h90, 1);
    check("R8 af at 4", 36'(almostFull), 36'd1);
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    testResetStd();
    testStdOrder();
    testFullAndAf();
    testFwft();
    testParallelAndPartial();
    testMasterDefaults();
    testSerial();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule